// File: doc/BRIEF.md
# Snooping Write-Back MSI Cache Controller

This block keeps one small direct-mapped write-back cache coherent with its peers on a shared bus whose transactions are atomic. Every line is Invalid, Shared (clean, read-only) or Exclusive (sole copy, writable, dirty). The processor side presents one request at a time and holds it until the controller pulses a completion that reports hit or miss and, for reads, the data. Misses arbitrate for the bus and issue a read-miss, write-miss or writeback command. Each bus transaction occupies one bus cycle and carries command, line address, requester id and data together.

On the snoop side the controller watches every miss placed on the bus by another cache. When it holds the addressed line dirty, it drives the line onto the response data lines and raises a single-cycle abort so that memory does not answer. It then invalidates the line or demotes it to Shared, depending on the command. The processor's own line state changes only in the cycle its bus command is issued. A snoop that touches the pending request's line before the grant arrives takes priority, and the request goes back through its lookup.

Lines hold one data word each, so a write miss fills the whole line with the processor's write data.

Top module: `snoop_msi_ctrl`

## Requirements
- R1: After reset every line is Invalid, and busReq, busOutValid, cpuDone and snpAbort are low.
- R2: A read whose tag matches a Shared or Exclusive line completes in the cycle after acceptance with cpuHit=1 and the stored data, and raises no bus request.
- R3: A write whose tag matches an Exclusive line completes in the cycle after acceptance with cpuHit=1, replaces the stored word, and raises no bus request.
- R4: A read that misses requests the bus. In the granted cycle it drives busOutCmd=0 (read miss) with the request address and own id, completes with cpuHit=0 and cpuRdata=memData, and leaves the line Shared holding memData.
- R5: A write to an Invalid line, or to a Shared line even with a matching tag, is a miss. In the granted cycle it drives busOutCmd=1 (write miss), completes with cpuHit=0, and leaves the line Exclusive holding the write data.
- R6: A miss whose index holds an Exclusive line with a different tag first uses a grant for busOutCmd=2 (writeback), carrying the old line address and its data. The miss command goes out only on a later grant.
- R7: A snooped write miss (command 1) from another id that matches a Shared or Exclusive line invalidates it. If the line was Exclusive, snpAbort=1 and snpData carries the line in that same cycle.
- R8: A snooped read miss (command 0) from another id that matches an Exclusive line raises snpAbort with the line data and leaves the line Shared. A match on a Shared line keeps it Shared with no abort.
- R9: A snoop carrying the controller's own id, a snoop with a non-matching tag, and a snooped writeback (command 2) change no line and raise no abort.
- R10: While a miss waits for its grant, a snoop that touches the line at the request's index suppresses any command that cycle. The lookup is then repeated against the updated line, so a writeback made unnecessary by the snoop is not issued.
- R11: busOutValid is high only in cycles where busReq and busGnt are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Processor request, held until cpuDone |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Word address (low IDX_W bits index, rest tag) |
| cpuWdata | input | DATA_W | Write data |
| cpuDone | output | 1 | Request completes this cycle |
| cpuHit | output | 1 | Completion was a hit |
| cpuRdata | output | DATA_W | Read data, valid with cpuDone on reads |
| busReq | output | 1 | Bus arbitration request |
| busGnt | input | 1 | Bus grant for this cycle |
| busOutValid | output | 1 | Own command on the bus this cycle |
| busOutCmd | output | 2 | 0 read miss, 1 write miss, 2 writeback |
| busOutAddr | output | ADDR_W | Line address of own command |
| busOutId | output | ID_W | Own requester id |
| busOutData | output | DATA_W | Writeback data |
| memData | input | DATA_W | Fill data returned in the granted miss cycle |
| snpValid | input | 1 | A bus command is visible for snooping |
| snpCmd | input | 2 | Snooped command code |
| snpAddr | input | ADDR_W | Snooped line address |
| snpId | input | ID_W | Snooped requester id |
| snpAbort | output | 1 | This cache supplies the line; memory must abort |
| snpData | output | DATA_W | Supplied line data |

## Verification
The two functions that collide are a pending processor miss and a snoop aimed at the same line. The bench withholds the grant so that a miss sits in its wait state, then injects a peer's read or write miss on the victim's or target's line. In one case the snoop removes the need for a writeback; in the other it invalidates the line being written. The reference model predicts the lost cycle, the repeated lookup and the command actually issued, and both are compared cycle by cycle against the outputs, including the abort and supplied data in the snoop cycle.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [1:0] {
    LINE_INV = 2'd0,
    LINE_SHR = 2'd1,
    LINE_EXC = 2'd2
  } lineState_t;

  typedef enum logic [1:0] {
    CMD_RDMISS = 2'd0,
    CMD_WRMISS = 2'd1,
    CMD_WBACK  = 2'd2,
    CMD_NONE   = 2'd3
  } busCmd_t;

  // strobes from request control into the line store
  typedef struct packed {
    logic wrHit;
    logic fillShr;
    logic fillExc;
    logic dropVictim;
  } dpStrobe_t;

endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 8,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [IDX_W-1:0]  reqIdx,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] fillData,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [IDX_W-1:0]  snpIdx,
  input  logic [TAG_W-1:0]  snpTag,
  input  logic [ID_W-1:0]   snpId,
  output lineState_t        lookState,
  output logic [TAG_W-1:0]  lookTag,
  output logic [DATA_W-1:0] lookData,
  output logic              snpTouch,
  output logic              snpAbort,
  output logic [DATA_W-1:0] snpData
);
  localparam int LINES = 1 << IDX_W;

  lineState_t        stArr   [LINES];
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [DATA_W-1:0] dataArr [LINES];

  logic snpLive;
  logic snpIsWr;

  assign snpIsWr  = (snpCmd == CMD_WRMISS);
  assign snpLive  = snpValid && (snpId != ID_W'(MY_ID)) &&
                    ((snpCmd == CMD_RDMISS) || snpIsWr);
  assign snpTouch = snpLive && (stArr[snpIdx] != LINE_INV) &&
                    (tagArr[snpIdx] == snpTag);
  assign snpAbort = snpTouch && (stArr[snpIdx] == LINE_EXC);
  assign snpData  = snpAbort ? dataArr[snpIdx] : '0;

  assign lookState = stArr[reqIdx];
  assign lookTag   = tagArr[reqIdx];
  assign lookData  = dataArr[reqIdx];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    lineState_t        st;
    logic [TAG_W-1:0]  tg;
    logic [DATA_W-1:0] dt;
    logic              reqSel;
    logic              snpSel;

    assign reqSel = (reqIdx == IDX_W'(g));
    assign snpSel = snpTouch && (snpIdx == IDX_W'(g));

    // a snoop takes the line first; control holds off on a shared index
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        st <= LINE_INV;
      end else if (snpSel) begin
        st <= snpIsWr ? LINE_INV : LINE_SHR;
      end else if (reqSel) begin
        if (strobe.dropVictim)   st <= LINE_INV;
        else if (strobe.fillShr) st <= LINE_SHR;
        else if (strobe.fillExc) st <= LINE_EXC;
      end
    end

    always_ff @(posedge clk) begin
      if (reqSel && (strobe.fillShr || strobe.fillExc)) tg <= reqTag;
      if (reqSel && strobe.fillShr) dt <= fillData;
      else if (reqSel && (strobe.wrHit || strobe.fillExc)) dt <= reqWdata;
    end

    assign stArr[g]   = st;
    assign tagArr[g]  = tg;
    assign dataArr[g] = dt;
  end

endmodule

// File: rtl/msi_req_fsm.sv
module msi_req_fsm
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cpuReq,
  input  logic                    cpuWe,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic [DATA_W-1:0]       cpuWdata,
  input  logic                    busGnt,
  input  logic [DATA_W-1:0]       fillData,
  input  lineState_t              lookState,
  input  logic [ADDR_W-IDX_W-1:0] lookTag,
  input  logic [DATA_W-1:0]       lookData,
  input  logic                    snpTouch,
  input  logic [IDX_W-1:0]        snpIdx,
  output dpStrobe_t               strobe,
  output logic [IDX_W-1:0]        reqIdx,
  output logic [ADDR_W-IDX_W-1:0] reqTag,
  output logic [DATA_W-1:0]       reqWdata,
  output logic                    cpuDone,
  output logic                    cpuHit,
  output logic [DATA_W-1:0]       cpuRdata,
  output logic                    busReq,
  output logic                    busOutValid,
  output logic [1:0]              busOutCmd,
  output logic [ADDR_W-1:0]       busOutAddr,
  output logic [DATA_W-1:0]       busOutData
);
  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_WBWAIT, ST_MISSWAIT} fsm_t;

  fsm_t              fsm, fsmNext;
  logic              rWe;
  logic [ADDR_W-1:0] rAddr;
  logic [DATA_W-1:0] rWd;

  logic conflict, tagEq, hit, needWb, grantUse;

  assign reqIdx   = rAddr[IDX_W-1:0];
  assign reqTag   = rAddr[ADDR_W-1:IDX_W];
  assign reqWdata = rWd;

  assign conflict = snpTouch && (snpIdx == reqIdx) && (fsm != ST_IDLE);
  assign tagEq    = (lookTag == reqTag);
  assign hit      = rWe ? ((lookState == LINE_EXC) && tagEq)
                        : ((lookState != LINE_INV) && tagEq);
  assign needWb   = (lookState == LINE_EXC) && !tagEq;

  assign busReq   = (fsm == ST_WBWAIT) || (fsm == ST_MISSWAIT);
  assign grantUse = busReq && busGnt && !conflict;

  always_comb begin
    busOutValid = grantUse;
    busOutCmd   = CMD_NONE;
    busOutAddr  = '0;
    busOutData  = '0;
    if (grantUse) begin
      if (fsm == ST_WBWAIT) begin
        busOutCmd  = CMD_WBACK;
        busOutAddr = {lookTag, reqIdx};
        busOutData = lookData;
      end else begin
        busOutCmd  = rWe ? CMD_WRMISS : CMD_RDMISS;
        busOutAddr = rAddr;
      end
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.wrHit      = (fsm == ST_CHECK) && !conflict && hit && rWe;
    strobe.dropVictim = (fsm == ST_WBWAIT) && grantUse;
    strobe.fillShr    = (fsm == ST_MISSWAIT) && grantUse && !rWe;
    strobe.fillExc    = (fsm == ST_MISSWAIT) && grantUse && rWe;
  end

  always_comb begin
    cpuDone  = ((fsm == ST_CHECK) && !conflict && hit) ||
               ((fsm == ST_MISSWAIT) && grantUse);
    cpuHit   = cpuDone && (fsm == ST_CHECK);
    cpuRdata = '0;
    if (cpuDone && !rWe) cpuRdata = (fsm == ST_CHECK) ? lookData : fillData;
  end

  always_comb begin
    fsmNext = fsm;
    case (fsm)
      ST_IDLE:     if (cpuReq) fsmNext = ST_CHECK;
      ST_CHECK:    if (!conflict) begin
                     if (hit)         fsmNext = ST_IDLE;
                     else if (needWb) fsmNext = ST_WBWAIT;
                     else             fsmNext = ST_MISSWAIT;
                   end
      ST_WBWAIT:   if (conflict) fsmNext = ST_CHECK;
                   else if (grantUse) fsmNext = ST_MISSWAIT;
      ST_MISSWAIT: if (conflict) fsmNext = ST_CHECK;
                   else if (grantUse) fsmNext = ST_IDLE;
      default:     fsmNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsm   <= ST_IDLE;
      rWe   <= 1'b0;
      rAddr <= '0;
      rWd   <= '0;
    end else begin
      fsm <= fsmNext;
      if ((fsm == ST_IDLE) && cpuReq) begin
        rWe   <= cpuWe;
        rAddr <= cpuAddr;
        rWd   <= cpuWdata;
      end
    end
  end

endmodule

// File: rtl/snoop_msi_ctrl.sv
module snoop_msi_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuDone,
  output logic              cpuHit,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReq,
  input  logic              busGnt,
  output logic              busOutValid,
  output logic [1:0]        busOutCmd,
  output logic [ADDR_W-1:0] busOutAddr,
  output logic [ID_W-1:0]   busOutId,
  output logic [DATA_W-1:0] busOutData,
  input  logic [DATA_W-1:0] memData,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [ID_W-1:0]   snpId,
  output logic              snpAbort,
  output logic [DATA_W-1:0] snpData
);
  localparam int TAG_W = ADDR_W - IDX_W;

  dpStrobe_t         strobe;
  lineState_t        lookState;
  logic [TAG_W-1:0]  lookTag, reqTag;
  logic [DATA_W-1:0] lookData, reqWdata;
  logic [IDX_W-1:0]  reqIdx;
  logic              snpTouch;

  assign busOutId = ID_W'(MY_ID);

  msi_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .busGnt(busGnt), .fillData(memData),
    .lookState(lookState), .lookTag(lookTag), .lookData(lookData),
    .snpTouch(snpTouch), .snpIdx(snpAddr[IDX_W-1:0]),
    .strobe(strobe), .reqIdx(reqIdx), .reqTag(reqTag), .reqWdata(reqWdata),
    .cpuDone(cpuDone), .cpuHit(cpuHit), .cpuRdata(cpuRdata),
    .busReq(busReq), .busOutValid(busOutValid), .busOutCmd(busOutCmd),
    .busOutAddr(busOutAddr), .busOutData(busOutData)
  );

  msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W),
                   .ID_W(ID_W), .MY_ID(MY_ID)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqIdx(reqIdx), .reqTag(reqTag), .reqWdata(reqWdata), .fillData(memData),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpIdx(snpAddr[IDX_W-1:0]),
    .snpTag(snpAddr[ADDR_W-1:IDX_W]), .snpId(snpId),
    .lookState(lookState), .lookTag(lookTag), .lookData(lookData),
    .snpTouch(snpTouch), .snpAbort(snpAbort), .snpData(snpData)
  );

endmodule

// File: rtl/snoop_msi_ctrl_chk.sv
module snoop_msi_ctrl_chk #(
  parameter int ID_W  = 2,
  parameter int MY_ID = 0
) (
  input logic            clk,
  input logic            rstN,
  input logic            busReq,
  input logic            busGnt,
  input logic            busOutValid,
  input logic [1:0]      busOutCmd,
  input logic            cpuDone,
  input logic            cpuHit,
  input logic            snpValid,
  input logic [ID_W-1:0] snpId,
  input logic            snpAbort
);

  always @(posedge clk) begin
    if (!rstN) begin
      assert_quiet_in_reset_R1: assert (!busReq && !busOutValid && !cpuDone);
    end
  end

  assert_hit_off_bus_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cpuDone && cpuHit) |-> !busReq);

  assert_miss_done_on_grant_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busOutValid && (busOutCmd != 2'd2)) |-> (cpuDone && !cpuHit));

  assert_wback_then_miss_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busOutValid && (busOutCmd == 2'd2)) |=> busReq);

  assert_abort_needs_peer_R9: assert property (@(posedge clk) disable iff (!rstN)
    snpAbort |-> (snpValid && (snpId != ID_W'(MY_ID))));

  assert_valid_needs_grant_R11: assert property (@(posedge clk) disable iff (!rstN)
    busOutValid |-> (busReq && busGnt));

endmodule

bind snoop_msi_ctrl snoop_msi_ctrl_chk #(.ID_W(ID_W), .MY_ID(MY_ID)) u_chk (.*);

// File: tb/snoop_msi_ctrl_tb.sv
`timescale 1ns/1ps
module snoop_msi_ctrl_tb;
  localparam int MY = 0;
  localparam int PEER = 1;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpuReq = 1'b0, cpuWe = 1'b0;
  logic [7:0] cpuAddr = '0, cpuWdata = '0, memData = '0;
  logic       snpValid = 1'b0;
  logic [1:0] snpCmd = '0, snpId = '0;
  logic [7:0] snpAddr = '0;
  logic       gntEn = 1'b1;
  logic       busGnt;

  logic       cpuDone, cpuHit, busReq, busOutValid, snpAbort;
  logic [7:0] cpuRdata, busOutAddr, busOutData, snpData;
  logic [1:0] busOutCmd, busOutId;

  assign busGnt = busReq && gntEn && !snpValid;

  always #10 clk = ~clk;

  snoop_msi_ctrl u_dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuDone(cpuDone), .cpuHit(cpuHit), .cpuRdata(cpuRdata),
    .busReq(busReq), .busGnt(busGnt), .busOutValid(busOutValid),
    .busOutCmd(busOutCmd), .busOutAddr(busOutAddr), .busOutId(busOutId),
    .busOutData(busOutData), .memData(memData), .snpValid(snpValid),
    .snpCmd(snpCmd), .snpAddr(snpAddr), .snpId(snpId),
    .snpAbort(snpAbort), .snpData(snpData)
  );

  int checks = 0;
  int failures = 0;
  string curReq = "R1";

  // behavioural reference: 0 invalid, 1 shared, 2 exclusive
  int         mSt [4];
  logic [5:0] mTag [4];
  logic [7:0] mData [4];
  int         ph = 0;          // 0 idle, 1 lookup, 2 await writeback grant, 3 await miss grant
  logic       rWe = 1'b0;
  logic [7:0] rAddr = '0, rWd = '0;

  logic       sTouch, conf, hitV, eReq, eVal, eDone, eHit, eAbort;
  logic [1:0] eCmd;
  logic [7:0] eAddr, eBData, eRd, eSData;
  int         sIdx, ri;

  task automatic predict();
    sIdx   = int'(snpAddr[1:0]);
    ri     = int'(rAddr[1:0]);
    sTouch = snpValid && (snpId != 2'(MY)) && (snpCmd < 2'd2) &&
             (mSt[sIdx] != 0) && (mTag[sIdx] == snpAddr[7:2]);
    conf   = sTouch && (sIdx == ri) && (ph != 0);
    hitV   = rWe ? (mSt[ri] == 2 && mTag[ri] == rAddr[7:2])
                 : (mSt[ri] != 0 && mTag[ri] == rAddr[7:2]);
    eReq   = (ph == 2) || (ph == 3);
    eVal   = eReq && busGnt && !conf;
    eCmd   = (ph == 2) ? 2'd2 : (rWe ? 2'd1 : 2'd0);
    eAddr  = (ph == 2) ? {mTag[ri], rAddr[1:0]} : rAddr;
    eBData = (ph == 2) ? mData[ri] : 8'h00;
    eDone  = (ph == 1 && !conf && hitV) || (ph == 3 && eVal);
    eHit   = (ph == 1);
    eRd    = (ph == 1) ? mData[ri] : memData;
    eAbort = sTouch && (mSt[sIdx] == 2);
    eSData = eAbort ? mData[sIdx] : 8'h00;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) mSt[i] = 0;
      ph = 0;
    end else begin
      predict();
      case (ph)
        0: if (cpuReq) begin rWe = cpuWe; rAddr = cpuAddr; rWd = cpuWdata; ph = 1; end
        1: if (!conf) begin
             if (hitV) begin if (rWe) mData[ri] = rWd; ph = 0; end
             else ph = (mSt[ri] == 2 && mTag[ri] != rAddr[7:2]) ? 2 : 3;
           end
        2: if (conf) ph = 1;
           else if (eVal) begin mSt[ri] = 0; ph = 3; end
        3: if (conf) ph = 1;
           else if (eVal) begin
             mTag[ri]  = rAddr[7:2];
             mData[ri] = rWe ? rWd : memData;
             mSt[ri]   = rWe ? 2 : 1;
             ph = 0;
           end
        default: ph = 0;
      endcase
      if (sTouch) begin
        if (snpCmd == 2'd1) mSt[sIdx] = 0;
        else if (mSt[sIdx] == 2) mSt[sIdx] = 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (!rstN) begin
      check(!busReq && !busOutValid && !cpuDone && !snpAbort, "R1", "quiet in reset",
            {busReq, busOutValid, cpuDone, snpAbort}, 0);
    end else begin
      predict();
      check(busReq == eReq, curReq, "busReq", busReq, eReq);
      check(busOutValid == eVal, curReq, "busOutValid", busOutValid, eVal);
      if (eVal) begin
        check(busOutCmd == eCmd, curReq, "busOutCmd", busOutCmd, eCmd);
        check(busOutAddr == eAddr, curReq, "busOutAddr", busOutAddr, eAddr);
        check(busOutId == 2'(MY), curReq, "busOutId", busOutId, MY);
        if (eCmd == 2'd2) check(busOutData == eBData, curReq, "busOutData", busOutData, eBData);
      end
      check(cpuDone == eDone, curReq, "cpuDone", cpuDone, eDone);
      if (eDone) begin
        check(cpuHit == eHit, curReq, "cpuHit", cpuHit, eHit);
        if (!rWe) check(cpuRdata == eRd, curReq, "cpuRdata", cpuRdata, eRd);
      end
      check(snpAbort == eAbort, curReq, "snpAbort", snpAbort, eAbort);
      if (eAbort) check(snpData == eSData, curReq, "snpData", snpData, eSData);
    end
  end

  task automatic cpuAccess(input logic we, input logic [7:0] a,
                           input logic [7:0] d, input logic [7:0] f);
    int n;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWdata = d; memData = f;
    n = 0;
    do begin @(negedge clk); #3; n++; end while (!cpuDone && n < 60);
    if (!cpuDone) check(1'b0, curReq, "request never completed", 0, 1);
    cpuReq = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [7:0] a, input logic [1:0] id);
    @(negedge clk);
    snpValid = 1'b1; snpCmd = c; snpAddr = a; snpId = id;
    @(negedge clk);
    snpValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    check(1'b0, curReq, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    curReq = "R1";
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curReq = "R4"; cpuAccess(1'b0, 8'h04, 8'h00, 8'h11);   // miss after reset
    curReq = "R2"; cpuAccess(1'b0, 8'h04, 8'h00, 8'hEE);   // shared read hit
    curReq = "R5"; cpuAccess(1'b1, 8'h04, 8'h22, 8'h00);   // write to shared, same tag
    curReq = "R3"; cpuAccess(1'b1, 8'h04, 8'h33, 8'h00);   // exclusive write hit
    curReq = "R2"; cpuAccess(1'b0, 8'h04, 8'h00, 8'hEE);   // exclusive read hit
    curReq = "R6"; cpuAccess(1'b0, 8'h08, 8'h00, 8'h44);   // dirty victim, read
    curReq = "R5"; cpuAccess(1'b1, 8'h0C, 8'h55, 8'h00);   // clean victim, write
    curReq = "R6"; cpuAccess(1'b1, 8'h10, 8'h66, 8'h00);   // dirty victim, write
    curReq = "R7"; snoop(2'd1, 8'h10, 2'(PEER));           // abort, invalidate
    cpuAccess(1'b0, 8'h10, 8'h00, 8'h67);
    cpuAccess(1'b0, 8'h05, 8'h00, 8'h21);
    snoop(2'd1, 8'h05, 2'(PEER));                          // shared, no abort
    cpuAccess(1'b0, 8'h05, 8'h00, 8'h23);
    curReq = "R8"; cpuAccess(1'b1, 8'h06, 8'h77, 8'h00);
    snoop(2'd0, 8'h06, 2'(PEER));                          // demote with abort
    snoop(2'd0, 8'h06, 2'(PEER));                          // already shared
    cpuAccess(1'b0, 8'h06, 8'h00, 8'hEE);
    cpuAccess(1'b1, 8'h06, 8'h78, 8'h00);
    curReq = "R9"; snoop(2'd1, 8'h06, 2'(MY));             // own id
    snoop(2'd0, 8'h46, 2'(PEER));                          // other tag
    snoop(2'd2, 8'h06, 2'(PEER));                          // writeback command
    cpuAccess(1'b0, 8'h06, 8'h00, 8'hEE);                  // still exclusive
    curReq = "R10";
    gntEn = 1'b0;
    fork
      cpuAccess(1'b0, 8'h0A, 8'h00, 8'hA5);
      begin
        repeat (3) @(negedge clk);
        snoop(2'd0, 8'h06, 2'(PEER));                      // removes the writeback
        repeat (2) @(negedge clk);
        gntEn = 1'b1;
      end
    join
    cpuAccess(1'b0, 8'h03, 8'h00, 8'h31);
    gntEn = 1'b0;
    fork
      cpuAccess(1'b1, 8'h03, 8'h39, 8'h00);
      begin
        repeat (3) @(negedge clk);
        snoop(2'd1, 8'h03, 2'(PEER));                      // invalidates the target
        repeat (2) @(negedge clk);
        gntEn = 1'b1;
      end
    join
    curReq = "R11";
    gntEn = 1'b0;
    fork
      cpuAccess(1'b0, 8'h0B, 8'h00, 8'hB1);
      begin repeat (5) @(negedge clk); gntEn = 1'b1; end
    join
    cpuAccess(1'b0, 8'h0B, 8'h00, 8'hEE);
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule